// File: doc/BRIEF.md
# DMA Snoop Tag Controller

This block sits beside a processor cache and watches direct-memory-access traffic on the memory bus. It holds a small direct-mapped tag store with a valid and a dirty flag per line. That store has two independent read ports. The processor side uses one port to look up and update lines. The other port is wired to the bus address, so a snoop lookup never takes a processor lookup cycle away.

For each bus strobe the block looks up the line in one cycle and picks one of three reactions. It can do nothing. It can take over the following bus cycle and supply its modified data, while holding memory off the bus. Or it can drop its copy. The choice depends on the transfer direction and on whether the line is clean or dirty. A DMA write always replaces a full line, so a dirty line hit by a DMA write is discarded without being written back.

The controller is a three-state machine:
- IDLE: snoops are accepted.
- SUPPLY: one cycle in which the cache drives data and inhibits memory.
- PURGE: one cycle that reports the dropped line.

Its transitions are:
- IDLE to SUPPLY on a DMA read that hits a dirty line.
- IDLE to PURGE on a DMA write that hits any line.
- IDLE to IDLE on every other case.
- SUPPLY to IDLE unconditionally.
- PURGE to IDLE unconditionally.

Top module: `dma_snoop_tagctl`

## Requirements
- R1: After reset every line is invalid, every lookup misses, and snoop_drive, mem_inhibit, snoop_purge and snoop_busy are low.
- R2: Address fields are offset in the low OFF_W bits, index in the next IDX_W bits and tag in the remaining high bits; a hit means the indexed line is valid and its tag matches. On the processor port, an operation with cpu_fill=1 installs the addressed line as valid and clean. An operation with cpu_fill=0 marks the line dirty only when it hits, and has no effect on a miss. cpu_hit and cpu_dirty (the dirty flag qualified by hit) are combinational from cpu_addr.
- R3: A snoop of either direction that misses causes no drive, no purge and no busy, and leaves every line unchanged.
- R4: A DMA read (bus_write=0) that hits a clean line causes no action, and the line stays valid and clean.
- R5: A DMA read that hits a dirty line, with the strobe sampled at edge E, raises snoop_drive and mem_inhibit together for exactly the one cycle after E, with snoop_index equal to the line index. The line stays valid and dirty.
- R6: A DMA write (bus_write=1) that hits a line invalidates it at edge E, clean or dirty, discarding the dirty data. snoop_purge is high for exactly the one cycle after E, with snoop_index equal to the line index.
- R7: snoop_busy is high in the SUPPLY and PURGE cycles, and a bus strobe presented while busy is ignored.
- R8: When a snoop purge and a processor fill target the same index in the same cycle, the purge wins and the line ends invalid. A fill to a different index in that cycle takes effect normally.
- R9: A processor lookup gives its correct result in the same cycle that a snoop lookup uses the other port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor operation strobe |
| cpu_fill | input | 1 | 1 = fill line clean, 0 = write (mark dirty on hit) |
| cpu_addr | input | ADDR_W | Processor address for lookup and operation |
| cpu_hit | output | 1 | Processor-port lookup hit |
| cpu_dirty | output | 1 | Processor-port line dirty (qualified by hit) |
| bus_valid | input | 1 | Bus cycle strobe |
| bus_write | input | 1 | 1 = DMA write to memory, 0 = DMA read from memory |
| bus_addr | input | ADDR_W | Bus address being snooped |
| snoop_drive | output | 1 | Cache drives line data on the bus |
| mem_inhibit | output | 1 | Memory must not drive the bus |
| snoop_purge | output | 1 | Matching line was dropped |
| snoop_index | output | IDX_W | Line index of the current drive or purge |
| snoop_busy | output | 1 | Snoop engine occupied; strobes ignored |

## Verification
The bench builds the block with an 8-bit address, a one-bit offset and a two-bit index. That gives four lines and five tag bits. Every line can then be taken through each starting condition (invalid, clean, dirty), each bus direction, and both a matching and a non-matching tag. The reaction and the resulting line state are compared against a small model for each case. The small size also makes the same-index priority, the busy-cycle drop and the concurrent two-port lookup cheap to set up on chosen lines.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SUPPLY = 2'd1,
        ST_PURGE  = 2'd2
    } snoop_state_t;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_SUPPLY = 2'd1,
        ACT_PURGE  = 2'd2
    } snoop_act_t;
endpackage

// File: rtl/snoop_tag_store.sv
module snoop_tag_store #(
    parameter int IDX_W = 3,
    parameter int TAG_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    // processor read port
    input  logic [IDX_W-1:0] a_idx,
    input  logic [TAG_W-1:0] a_tag,
    output logic             a_hit,
    output logic             a_dirty,
    // snoop read port
    input  logic [IDX_W-1:0] b_idx,
    input  logic [TAG_W-1:0] b_tag,
    output logic             b_hit,
    output logic             b_dirty,
    // updates
    input  logic             inv_en,
    input  logic [IDX_W-1:0] inv_idx,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             mark_en,
    input  logic [IDX_W-1:0] mark_idx
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // Two independent combinational read ports
    always_comb begin
        a_hit   = valid_q[a_idx] && (tag_q[a_idx] == a_tag);
        a_dirty = dirty_q[a_idx];
        b_hit   = valid_q[b_idx] && (tag_q[b_idx] == b_tag);
        b_dirty = dirty_q[b_idx];
    end

    // Per-line update with fixed priority: invalidate, then fill, then mark
    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic inv_here, fill_here, mark_here;
        always_comb begin
            inv_here  = inv_en  && (inv_idx  == IDX_W'(i));
            fill_here = fill_en && (fill_idx == IDX_W'(i));
            mark_here = mark_en && (mark_idx == IDX_W'(i));
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[i] <= 1'b0;
                dirty_q[i] <= 1'b0;
                tag_q[i]   <= '0;
            end else if (inv_here) begin
                valid_q[i] <= 1'b0;
                dirty_q[i] <= 1'b0;
            end else if (fill_here) begin
                valid_q[i] <= 1'b1;
                dirty_q[i] <= 1'b0;
                tag_q[i]   <= fill_tag;
            end else if (mark_here) begin
                dirty_q[i] <= 1'b1;
            end
        end
    end

    p_inv_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        inv_en |=> !valid_q[$past(inv_idx)]);

    p_inv_beats_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && fill_en && inv_idx == fill_idx) |=> !valid_q[$past(fill_idx)]);

    p_fill_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !(inv_en && inv_idx == fill_idx))
            |=> (valid_q[$past(fill_idx)] && !dirty_q[$past(fill_idx)]));
endmodule

// File: rtl/snoop_decide.sv
module snoop_decide
    import snoop_pkg::*;
(
    input  logic       strobe,
    input  logic       accept,
    input  logic       hit,
    input  logic       dirty,
    input  logic       is_write,
    output snoop_act_t act
);
    always_comb begin
        act = ACT_NONE;
        if (strobe && accept && hit) begin
            if (is_write)
                act = ACT_PURGE;
            else if (dirty)
                act = ACT_SUPPLY;
        end
    end
endmodule

// File: rtl/snoop_fsm.sv
module snoop_fsm
    import snoop_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  snoop_act_t       act,
    input  logic [IDX_W-1:0] idx_in,
    output logic             accept,
    output logic             purge_now,
    output logic             drive,
    output logic             inhibit,
    output logic             purge,
    output logic             busy,
    output logic [IDX_W-1:0] idx_out
);
    snoop_state_t state_q, state_d;
    logic [IDX_W-1:0] idx_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (act == ACT_SUPPLY)
                    state_d = ST_SUPPLY;
                else if (act == ACT_PURGE)
                    state_d = ST_PURGE;
            end
            ST_SUPPLY: state_d = ST_IDLE;
            ST_PURGE:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (act != ACT_NONE)
                idx_q <= idx_in;
        end
    end

    always_comb begin
        accept    = (state_q == ST_IDLE);
        purge_now = (act == ACT_PURGE);
        drive     = (state_q == ST_SUPPLY);
        inhibit   = (state_q == ST_SUPPLY);
        purge     = (state_q == ST_PURGE);
        busy      = (state_q != ST_IDLE);
        idx_out   = idx_q;
    end

    p_supply_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SUPPLY) |=> (state_q == ST_IDLE));

    p_purge_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PURGE) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/dma_snoop_tagctl.sv
module dma_snoop_tagctl
    import snoop_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 2,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_fill,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_hit,
    output logic              cpu_dirty,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              snoop_drive,
    output logic              mem_inhibit,
    output logic              snoop_purge,
    output logic [IDX_W-1:0]  snoop_index,
    output logic              snoop_busy
);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int IDX_LO = OFF_W;
    localparam int TAG_LO = OFF_W + IDX_W;

    logic [IDX_W-1:0] c_idx, s_idx;
    logic [TAG_W-1:0] c_tag, s_tag;
    logic             a_hit, a_dirty, b_hit, b_dirty;
    logic             accept, purge_now;
    logic             fill_en, mark_en;
    snoop_act_t       act;

    always_comb begin
        c_idx   = cpu_addr[IDX_LO +: IDX_W];
        c_tag   = cpu_addr[TAG_LO +: TAG_W];
        s_idx   = bus_addr[IDX_LO +: IDX_W];
        s_tag   = bus_addr[TAG_LO +: TAG_W];
        fill_en = cpu_valid && cpu_fill;
        mark_en = cpu_valid && !cpu_fill && a_hit;
        cpu_hit   = a_hit;
        cpu_dirty = a_hit && a_dirty;
    end

    snoop_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_idx    (c_idx),
        .a_tag    (c_tag),
        .a_hit    (a_hit),
        .a_dirty  (a_dirty),
        .b_idx    (s_idx),
        .b_tag    (s_tag),
        .b_hit    (b_hit),
        .b_dirty  (b_dirty),
        .inv_en   (purge_now),
        .inv_idx  (s_idx),
        .fill_en  (fill_en),
        .fill_idx (c_idx),
        .fill_tag (c_tag),
        .mark_en  (mark_en),
        .mark_idx (c_idx)
    );

    snoop_decide u_decide (
        .strobe   (bus_valid),
        .accept   (accept),
        .hit      (b_hit),
        .dirty    (b_dirty),
        .is_write (bus_write),
        .act      (act)
    );

    snoop_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act),
        .idx_in    (s_idx),
        .accept    (accept),
        .purge_now (purge_now),
        .drive     (snoop_drive),
        .inhibit   (mem_inhibit),
        .purge     (snoop_purge),
        .busy      (snoop_busy),
        .idx_out   (snoop_index)
    );

    p_drive_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_drive |-> $past(bus_valid && !bus_write && !snoop_busy));

    p_purge_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_purge |-> $past(bus_valid && bus_write && !snoop_busy));

    p_busy_ignores_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_busy && bus_valid) |=> (!snoop_drive && !snoop_purge));

    p_drive_purge_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(snoop_drive && snoop_purge));
endmodule

// File: tb/dma_snoop_tagctl_tb.sv
module dma_snoop_tagctl_tb;
    localparam int AW = 8;
    localparam int OW = 1;
    localparam int IW = 2;
    localparam int TW = AW - OW - IW;
    localparam int NL = 1 << IW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_valid = 1'b0, cpu_fill = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic cpu_hit, cpu_dirty;
    logic bus_valid = 1'b0, bus_write = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic snoop_drive, mem_inhibit, snoop_purge, snoop_busy;
    logic [IW-1:0] snoop_index;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    bit          m_valid [NL];
    bit          m_dirty [NL];
    logic [TW-1:0] m_tag [NL];

    always #5 clk = ~clk;

    dma_snoop_tagctl #(.ADDR_W(AW), .OFF_W(OW), .IDX_W(IW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_fill(cpu_fill), .cpu_addr(cpu_addr),
        .cpu_hit(cpu_hit), .cpu_dirty(cpu_dirty),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .snoop_drive(snoop_drive), .mem_inhibit(mem_inhibit),
        .snoop_purge(snoop_purge), .snoop_index(snoop_index),
        .snoop_busy(snoop_busy)
    );

    function automatic logic [AW-1:0] mk(logic [TW-1:0] t, int idx, int off);
        return {t, IW'(idx), OW'(off)};
    endfunction

    function automatic int ix(logic [AW-1:0] a);
        return int'(a[OW +: IW]);
    endfunction

    function automatic logic [TW-1:0] tg(logic [AW-1:0] a);
        return a[OW+IW +: TW];
    endfunction

    function automatic bit m_hit(logic [AW-1:0] a);
        return m_valid[ix(a)] && (m_tag[ix(a)] == tg(a));
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic quiet(string req);
        chk(req, "drive",   32'(snoop_drive), 0);
        chk(req, "inhibit", 32'(mem_inhibit), 0);
        chk(req, "purge",   32'(snoop_purge), 0);
        chk(req, "busy",    32'(snoop_busy),  0);
    endtask

    task automatic look(string req, logic [AW-1:0] a);
        @(negedge clk);
        cpu_addr = a;
        #1;
        chk(req, "cpu_hit",   32'(cpu_hit),   32'(m_hit(a)));
        chk(req, "cpu_dirty", 32'(cpu_dirty), 32'(m_hit(a) && m_dirty[ix(a)]));
    endtask

    task automatic cpu_op(bit fill, logic [AW-1:0] a);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_fill = fill; cpu_addr = a;
        @(negedge clk);
        cpu_valid = 1'b0;
        if (fill) begin
            m_valid[ix(a)] = 1'b1; m_dirty[ix(a)] = 1'b0; m_tag[ix(a)] = tg(a);
        end else if (m_hit(a)) begin
            m_dirty[ix(a)] = 1'b1;
        end
    endtask

    task automatic snoop(bit wr, logic [AW-1:0] a, string req);
        bit h, exp_sup, exp_pur;
        h = m_hit(a);
        exp_sup = h && !wr && m_dirty[ix(a)];
        exp_pur = h && wr;
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        chk(req, "drive",   32'(snoop_drive), 32'(exp_sup));
        chk(req, "inhibit", 32'(mem_inhibit), 32'(exp_sup));
        chk(req, "purge",   32'(snoop_purge), 32'(exp_pur));
        chk(req, "busy",    32'(snoop_busy),  32'(exp_sup || exp_pur));
        if (exp_sup || exp_pur)
            chk(req, "index", 32'(snoop_index), 32'(ix(a)));
        if (exp_pur) begin
            m_valid[ix(a)] = 1'b0; m_dirty[ix(a)] = 1'b0;
        end
        @(negedge clk);
        quiet(req);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NL; i++) begin
            m_valid[i] = 1'b0; m_dirty[i] = 1'b0; m_tag[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        quiet("R1");
        for (int i = 0; i < NL; i++) look("R1", mk('0, i, 0));

        // R2 write on miss ignored, fill clean, write marks dirty
        cpu_op(1'b0, mk(5'd9, 1, 0));
        look("R2", mk(5'd9, 1, 0));
        cpu_op(1'b1, mk(5'd9, 1, 0));
        look("R2", mk(5'd9, 1, 1));
        cpu_op(1'b0, mk(5'd9, 1, 1));
        look("R2", mk(5'd9, 1, 0));
        cpu_op(1'b0, mk(5'd8, 1, 0));
        look("R2", mk(5'd9, 1, 0));

        // Sweep: line x start condition x direction x tag match
        for (int idx = 0; idx < NL; idx++) begin
            for (int pre = 0; pre < 3; pre++) begin
                for (int wr = 0; wr < 2; wr++) begin
                    for (int same = 0; same < 2; same++) begin
                        logic [TW-1:0] t, o;
                        string rq;
                        t = TW'(3 + idx * 7);
                        o = t ^ TW'(5'h10);
                        cpu_op(1'b1, mk(t, idx, 0));
                        if (pre == 2) cpu_op(1'b0, mk(t, idx, 1));
                        if (pre == 0) snoop(1'b1, mk(t, idx, 0), "R6");
                        look("R2", mk(t, idx, 0));
                        if (same == 0 || pre == 0) rq = "R3";
                        else if (wr == 1) rq = "R6";
                        else if (pre == 2) rq = "R5";
                        else rq = "R4";
                        snoop(wr[0], mk(same ? t : o, idx, idx & 1), rq);
                        look(rq, mk(t, idx, 0));
                        look(rq, mk(o, idx, 0));
                    end
                end
            end
        end

        // R7 strobe during busy is ignored
        cpu_op(1'b1, mk(5'd2, 0, 0));
        cpu_op(1'b0, mk(5'd2, 0, 0));
        cpu_op(1'b1, mk(5'd4, 1, 0));
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = mk(5'd2, 0, 0);
        @(negedge clk);
        chk("R7", "drive", 32'(snoop_drive), 1);
        chk("R7", "busy",  32'(snoop_busy),  1);
        bus_write = 1'b1; bus_addr = mk(5'd4, 1, 0);
        @(negedge clk);
        bus_valid = 1'b0;
        chk("R7", "purge", 32'(snoop_purge), 0);
        chk("R7", "drive", 32'(snoop_drive), 0);
        look("R7", mk(5'd4, 1, 0));
        look("R5", mk(5'd2, 0, 0));

        // R8 purge beats fill to the same index
        cpu_op(1'b1, mk(5'd6, 2, 0));
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = mk(5'd6, 2, 0);
        cpu_valid = 1'b1; cpu_fill = 1'b1; cpu_addr = mk(5'd11, 2, 0);
        @(negedge clk);
        bus_valid = 1'b0; cpu_valid = 1'b0;
        chk("R8", "purge", 32'(snoop_purge), 1);
        m_valid[2] = 1'b0; m_dirty[2] = 1'b0;
        look("R8", mk(5'd11, 2, 0));
        look("R8", mk(5'd6, 2, 0));

        // R8 fill to a different index proceeds
        cpu_op(1'b1, mk(5'd13, 3, 0));
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = mk(5'd13, 3, 0);
        cpu_valid = 1'b1; cpu_fill = 1'b1; cpu_addr = mk(5'd20, 0, 0);
        @(negedge clk);
        bus_valid = 1'b0; cpu_valid = 1'b0;
        chk("R8", "purge", 32'(snoop_purge), 1);
        chk("R8", "index", 32'(snoop_index), 3);
        m_valid[3] = 1'b0; m_dirty[3] = 1'b0;
        m_valid[0] = 1'b1; m_dirty[0] = 1'b0; m_tag[0] = 5'd20;
        look("R8", mk(5'd20, 0, 0));
        look("R8", mk(5'd13, 3, 0));

        // R9 processor lookup concurrent with snoop lookup
        cpu_op(1'b1, mk(5'd17, 3, 0));
        cpu_op(1'b0, mk(5'd17, 3, 0));
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = mk(5'd4, 1, 0);
        cpu_addr = mk(5'd17, 3, 1);
        #1;
        chk("R9", "cpu_hit",   32'(cpu_hit),   1);
        chk("R9", "cpu_dirty", 32'(cpu_dirty), 1);
        @(negedge clk);
        bus_valid = 1'b0;
        chk("R9", "purge", 32'(snoop_purge), 1);
        m_valid[1] = 1'b0; m_dirty[1] = 1'b0;
        look("R9", mk(5'd4, 1, 0));
        look("R9", mk(5'd17, 3, 0));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule